// File: doc/BRIEF.md
# Decode Stage Skid-Buffer Controller

This block sits between instruction fetch and the next stage of a multi-threaded decode pipeline. Every cycle it receives a fetch group of up to `FW` slots. Each slot carries a valid bit, a kill bit, a thread number and a sequence number. The block steers the slots into per-thread lanes and forwards at most `DW` instructions per cycle downstream, in program order within each thread. Lower-numbered threads take free lanes first. Results appear on registered outputs one cycle after the inputs that produced them.

Each downstream stage (rename, execute, commit) can hold a thread with a block pulse and release it with an unblock pulse. While a thread is held, its incoming instructions collect in a private skid FIFO. The FIFO holds `FD_LAT*FW+DW` entries, which covers the fetch groups already in flight plus one decode group. When the hold ends, the thread first drains its FIFO, and any new fetch input queues behind the older entries. The block talks to fetch with one-cycle block and unblock pulses per thread. A squash from commit empties the thread's FIFO and drops its incoming slots.

Top module: `dsk_decode_skid`

## Requirements
- R1: After reset every thread state reads Idle, no output lane is valid and no fetch pulse is raised. Thread states are encoded as Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4, in field `thr_state[3*t+2:3*t]`.
- R2: Each thread keeps three sticky hold flags, one each for rename, execute and commit. A flag is set by its block pulse and cleared only by its own unblock pulse. A thread counts as held, in the same cycle, while any flag is set after that cycle's pulses are applied.
- R3: Each skid FIFO holds `FD_LAT*FW+DW` entries and returns them in insertion order. A full FIFO drains completely.
- R4: At most `DW` lanes are valid per cycle, and the valid lanes are packed from lane 0. Lanes are filled by thread number ascending, in program order within each thread. Outputs are registered one cycle after the inputs. A thread with pending work leaves Idle for Running.
- R5: A fetch slot with its kill bit set is dropped and uses no output lane.
- R6: If a thread that is not Blocked or Unblocking has more instructions than free lanes, the leftovers go to its skid FIFO, its state becomes Blocked, and its `fe_block` bit pulses for one cycle.
- R7: While a thread is held, its incoming slots go to its FIFO and nothing is forwarded. `fe_block` pulses only on the cycle the thread enters Blocked, not again while it stays Blocked.
- R8: When the hold ends, FIFO entries are forwarded before new fetch input, and new input is appended behind them. While entries remain the state reads Unblocking. The cycle the FIFO empties, the state becomes Running and `fe_unblock` pulses.
- R9: A commit squash drops the thread's incoming slots, empties its FIFO and sets Squashing. `fe_unblock` pulses only if the thread was Blocked or Unblocking. The thread forwards nothing in that cycle.
- R10: The squash-in-progress input holds Squashing and drops incoming slots. The first cycle with neither squash input and no hold moves Squashing to Running.
- R11: The inputs are ranked as follows: squash first, then squash-in-progress, then any hold, and only then normal flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fg_vld | input | FW | Fetch slot valid |
| fg_kill | input | FW | Fetch slot already squashed |
| fg_tid | input | FW*TID_W | Thread number per slot |
| fg_seq | input | FW*SEQ_W | Sequence number per slot |
| rn_block | input | NT | Rename hold pulse per thread |
| rn_unblock | input | NT | Rename release pulse per thread |
| ex_block | input | NT | Execute hold pulse per thread |
| ex_unblock | input | NT | Execute release pulse per thread |
| cm_block | input | NT | Commit hold pulse per thread |
| cm_unblock | input | NT | Commit release pulse per thread |
| cm_squash | input | NT | Commit squash per thread |
| cm_busy | input | NT | Commit still squashing per thread |
| out_vld | output | DW | Output lane valid |
| out_tid | output | DW*TID_W | Output lane thread number |
| out_seq | output | DW*SEQ_W | Output lane sequence number |
| fe_block | output | NT | Block pulse to fetch |
| fe_unblock | output | NT | Unblock pulse to fetch |
| thr_state | output | NT*3 | Per-thread state code |

## Verification
A corrupt FIFO pointer or count shows up at the output lanes within a cycle or two of the thread's next drain. Sequence numbers then come out repeated, skipped or out of order, so checking sequence order per thread catches it. A wrong state transition shows on `thr_state` on the next edge. It also shows as a missing, doubled or misplaced `fe_block`/`fe_unblock` pulse on the cycle of the transition. A lost hold flag makes a held thread forward lanes in the very cycle it should stay silent.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
   typedef enum logic [2:0] {
      TS_IDLE   = 3'd0,
      TS_RUN    = 3'd1,
      TS_BLOCK  = 3'd2,
      TS_UNBLK  = 3'd3,
      TS_SQUASH = 3'd4
   } thr_state_t;

   function automatic int min_i(input int a, input int b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/dsk_stall_flags.sv
module dsk_stall_flags #(
   parameter int NT   = 2,
   parameter int NSRC = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSRC-1:0][NT-1:0]   hold_set,
   input  logic [NSRC-1:0][NT-1:0]   hold_clr,
   output logic [NT-1:0]             held
);
   logic [NSRC-1:0][NT-1:0] flg, flg_nx;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign flg_nx[s] = (flg[s] | hold_set[s]) & ~hold_clr[s];

      // R2: a release only arrives for a flag that is (or becomes) set
      p_release_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (hold_clr[s] & ~(flg[s] | hold_set[s])) == '0);
   end

   always_comb begin
      held = '0;
      for (int s = 0; s < NSRC; s++) held = held | flg_nx[s];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flg <= '0;
      else        flg <= flg_nx;
   end
endmodule

// File: rtl/dsk_skid_fifo.sv
module dsk_skid_fifo #(
   parameter  int DEPTH    = 10,
   parameter  int W        = 8,
   parameter  int PUSH_MAX = 4,
   parameter  int PEEK     = 2,
   localparam int CW       = $clog2(DEPTH + 1),
   localparam int PW       = $clog2(PUSH_MAX + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic [CW-1:0]                pop_n,
   input  logic [PW-1:0]                push_n,
   input  logic [PUSH_MAX-1:0][W-1:0]   push_d,
   output logic [CW-1:0]                cnt,
   output logic [PEEK-1:0][W-1:0]       peek
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1 || PEEK > DEPTH || PUSH_MAX < 1) begin : g_cfg_bad
      $error("dsk_skid_fifo: DEPTH must cover PEEK and be nonzero");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [IW-1:0] head;

   function automatic logic [IW-1:0] slot(input int base, input int ofs);
      return IW'((base + ofs) % DEPTH);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         cnt  <= '0;
      end else if (clr) begin
         head <= '0;
         cnt  <= '0;
      end else begin
         head <= slot(int'(head), int'(pop_n));
         cnt  <= CW'(int'(cnt) - int'(pop_n) + int'(push_n));
      end
   end

   always_ff @(posedge clk) begin
      if (rst_n && !clr) begin
         for (int i = 0; i < PUSH_MAX; i++)
            if (i < int'(push_n)) mem[slot(int'(head), int'(cnt) + i)] <= push_d[i];
      end
   end

   always_comb begin
      for (int j = 0; j < PEEK; j++) peek[j] = mem[slot(int'(head), j)];
   end

   // R3: occupancy never exceeds the configured capacity
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (int'(cnt) + int'(push_n) - int'(pop_n)) <= DEPTH);
   // R8: the drain never takes more than is stored
   p_pop_within_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> int'(pop_n) <= int'(cnt));
endmodule

// File: rtl/dsk_thread_ctl.sv
module dsk_thread_ctl
   import dsk_pkg::*;
#(
   parameter  int FW     = 4,
   parameter  int DW     = 2,
   parameter  int DEPTH  = 10,
   parameter  int SEQ_W  = 8,
   parameter  int TID_W  = 1,
   parameter  int MY_TID = 0,
   localparam int SW     = $clog2(DW + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [FW-1:0]                 fg_vld,
   input  logic [FW-1:0]                 fg_kill,
   input  logic [FW-1:0][TID_W-1:0]      fg_tid,
   input  logic [FW-1:0][SEQ_W-1:0]      fg_seq,
   input  logic                          squash,
   input  logic                          busy,
   input  logic                          held,
   input  logic [SW-1:0]                 slots,
   output logic [SW-1:0]                 sent_n,
   output logic [DW-1:0][SEQ_W-1:0]      sent_seq,
   output thr_state_t                    state,
   output logic                          fe_blk,
   output logic                          fe_ublk
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int PW = $clog2(FW + 1);

   logic [FW-1:0][SEQ_W-1:0] inc, pdat;
   logic [DW-1:0][SEQ_W-1:0] peek;
   logic [CW-1:0]            cnt, pop_n;
   logic [PW-1:0]            push_n;
   thr_state_t               st_nx;
   logic                     b_nx, u_nx;

   always_comb begin
      int nin, avail, n, pop, k, rem, cnt_i;
      bit go, draining;
      inc  = '0;
      pdat = '0;
      nin  = 0;
      for (int i = 0; i < FW; i++) begin
         if (fg_vld[i] && !fg_kill[i] && fg_tid[i] == TID_W'(MY_TID)) begin
            inc[nin] = fg_seq[i];
            nin++;
         end
      end
      cnt_i = int'(cnt);
      avail = cnt_i + nin;
      for (int j = 0; j < DW; j++) begin
         if (j < cnt_i)               sent_seq[j] = peek[j];
         else if (j - cnt_i < FW)     sent_seq[j] = inc[j - cnt_i];
         else                         sent_seq[j] = '0;
      end
      go    = !squash && !busy && !held;
      n     = go ? min_i(avail, int'(slots)) : 0;
      pop   = min_i(n, cnt_i);
      k     = n - pop;
      rem   = avail - n;
      for (int i = 0; i < FW; i++)
         if (i + k < FW) pdat[i] = inc[i + k];
      sent_n = SW'(n);
      pop_n  = CW'(pop);
      if (go)                        push_n = PW'(nin - k);
      else if (!squash && !busy)     push_n = PW'(nin);
      else                           push_n = '0;

      draining = (state == TS_BLOCK) || (state == TS_UNBLK);
      st_nx = state;
      b_nx  = 1'b0;
      u_nx  = 1'b0;
      if (squash) begin
         st_nx = TS_SQUASH;
         u_nx  = draining;
      end else if (busy) begin
         st_nx = TS_SQUASH;
      end else if (held) begin
         st_nx = TS_BLOCK;
         b_nx  = (state != TS_BLOCK);
      end else if (draining) begin
         if (rem == 0) begin
            st_nx = TS_RUN;
            u_nx  = 1'b1;
         end else begin
            st_nx = TS_UNBLK;
         end
      end else if (rem > 0) begin
         st_nx = TS_BLOCK;
         b_nx  = 1'b1;
      end else if (state == TS_SQUASH || avail > 0) begin
         st_nx = TS_RUN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= TS_IDLE;
         fe_blk  <= 1'b0;
         fe_ublk <= 1'b0;
      end else begin
         state   <= st_nx;
         fe_blk  <= b_nx;
         fe_ublk <= u_nx;
      end
   end

   dsk_skid_fifo #(
      .DEPTH(DEPTH), .W(SEQ_W), .PUSH_MAX(FW), .PEEK(DW)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(squash),
      .pop_n(pop_n), .push_n(push_n), .push_d(pdat),
      .cnt(cnt), .peek(peek)
   );

   // R6: only Blocked and Unblocking may hold skid entries
   p_quiet_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TS_IDLE || state == TS_RUN || state == TS_SQUASH) |-> cnt == '0);
   // R7: a block pulse always accompanies the Blocked state
   p_block_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fe_blk |-> state == TS_BLOCK);
   // R8: an unblock pulse leaves the thread Running or Squashing
   p_unblock_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fe_ublk |-> (state == TS_RUN || state == TS_SQUASH));
   // R9: a squash leaves the skid FIFO empty on the next cycle
   p_squash_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> cnt == '0);
endmodule

// File: rtl/dsk_decode_skid.sv
module dsk_decode_skid
   import dsk_pkg::*;
#(
   parameter  int NT     = 2,
   parameter  int FW     = 4,
   parameter  int DW     = 2,
   parameter  int FD_LAT = 2,
   parameter  int SEQ_W  = 8,
   localparam int TID_W  = (NT > 1) ? $clog2(NT) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [FW-1:0]        fg_vld,
   input  logic [FW-1:0]        fg_kill,
   input  logic [FW*TID_W-1:0]  fg_tid,
   input  logic [FW*SEQ_W-1:0]  fg_seq,
   input  logic [NT-1:0]        rn_block,
   input  logic [NT-1:0]        rn_unblock,
   input  logic [NT-1:0]        ex_block,
   input  logic [NT-1:0]        ex_unblock,
   input  logic [NT-1:0]        cm_block,
   input  logic [NT-1:0]        cm_unblock,
   input  logic [NT-1:0]        cm_squash,
   input  logic [NT-1:0]        cm_busy,
   output logic [DW-1:0]        out_vld,
   output logic [DW*TID_W-1:0]  out_tid,
   output logic [DW*SEQ_W-1:0]  out_seq,
   output logic [NT-1:0]        fe_block,
   output logic [NT-1:0]        fe_unblock,
   output logic [NT*3-1:0]      thr_state
);
   localparam int DEPTH = FD_LAT * FW + DW;
   localparam int SW    = $clog2(DW + 1);

   if (NT < 1 || FW < 1 || DW < 1 || FD_LAT < 1 || SEQ_W < 1) begin : g_cfg_bad
      $error("dsk_decode_skid: every size parameter must be at least one");
   end

   logic [FW-1:0][TID_W-1:0]          tid_a;
   logic [FW-1:0][SEQ_W-1:0]          seq_a;
   logic [NT-1:0]                     held;
   logic [NT:0][SW-1:0]               off;
   logic [NT-1:0][SW-1:0]             sent_n;
   logic [NT-1:0][DW-1:0][SEQ_W-1:0]  sent_seq;
   logic [DW-1:0]                     lane_v;
   logic [DW-1:0][TID_W-1:0]          lane_t;
   logic [DW-1:0][SEQ_W-1:0]          lane_s;

   for (genvar i = 0; i < FW; i++) begin : g_slot
      assign tid_a[i] = fg_tid[i*TID_W +: TID_W];
      assign seq_a[i] = fg_seq[i*SEQ_W +: SEQ_W];
   end

   dsk_stall_flags #(.NT(NT), .NSRC(3)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .hold_set({cm_block, ex_block, rn_block}),
      .hold_clr({cm_unblock, ex_unblock, rn_unblock}),
      .held(held)
   );

   assign off[0] = '0;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      thr_state_t st;
      logic       hit;

      dsk_thread_ctl #(
         .FW(FW), .DW(DW), .DEPTH(DEPTH), .SEQ_W(SEQ_W),
         .TID_W(TID_W), .MY_TID(t)
      ) u_ctl (
         .clk(clk), .rst_n(rst_n),
         .fg_vld(fg_vld), .fg_kill(fg_kill), .fg_tid(tid_a), .fg_seq(seq_a),
         .squash(cm_squash[t]), .busy(cm_busy[t]), .held(held[t]),
         .slots(SW'(DW - int'(off[t]))),
         .sent_n(sent_n[t]), .sent_seq(sent_seq[t]),
         .state(st), .fe_blk(fe_block[t]), .fe_ublk(fe_unblock[t])
      );

      assign off[t+1]           = SW'(int'(off[t]) + int'(sent_n[t]));
      assign thr_state[3*t +: 3] = st;

      always_comb begin
         hit = 1'b0;
         for (int l = 0; l < DW; l++)
            if (out_vld[l] && out_tid[l*TID_W +: TID_W] == TID_W'(t)) hit = 1'b1;
      end

      // R9: a squashed thread owns no output lane on the next cycle
      p_squash_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
         cm_squash[t] |=> !hit);
      // R7: a held thread forwards nothing on the next cycle
      p_held_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
         held[t] |=> !hit);
   end

   always_comb begin
      lane_v = '0;
      lane_t = '0;
      lane_s = '0;
      for (int l = 0; l < DW; l++) begin
         for (int t = 0; t < NT; t++) begin
            if (l >= int'(off[t]) && l < int'(off[t+1])) begin
               lane_v[l] = 1'b1;
               lane_t[l] = TID_W'(t);
               lane_s[l] = sent_seq[t][l - int'(off[t])];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= '0;
         out_tid <= '0;
         out_seq <= '0;
      end else begin
         out_vld <= lane_v;
         out_tid <= lane_t;
         out_seq <= lane_s;
      end
   end

   // R4: valid lanes are packed from lane zero
   p_lanes_packed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == DW'((1 << $countones(out_vld)) - 1));
   // R1: no fetch pulse while reset was asserted on the previous edge
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (fe_block == '0 && fe_unblock == '0 && out_vld == '0));
endmodule

// File: tb/sim_dsk_decode_skid.sv
`timescale 1ns/1ps
module sim_dsk_decode_skid;
   localparam int NT = 2, FW = 4, DW = 2, FD_LAT = 2, SEQ_W = 8, TID_W = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [FW-1:0]        fg_vld, fg_kill;
   logic [FW*TID_W-1:0]  fg_tid;
   logic [FW*SEQ_W-1:0]  fg_seq;
   logic [NT-1:0] rn_block, rn_unblock, ex_block, ex_unblock;
   logic [NT-1:0] cm_block, cm_unblock, cm_squash, cm_busy;
   logic [DW-1:0]        out_vld;
   logic [DW*TID_W-1:0]  out_tid;
   logic [DW*SEQ_W-1:0]  out_seq;
   logic [NT-1:0]        fe_block, fe_unblock;
   logic [NT*3-1:0]      thr_state;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dsk_decode_skid #(.NT(NT), .FW(FW), .DW(DW), .FD_LAT(FD_LAT), .SEQ_W(SEQ_W)) u0 (
      .clk(clk), .rst_n(rst_n), .fg_vld(fg_vld), .fg_kill(fg_kill),
      .fg_tid(fg_tid), .fg_seq(fg_seq),
      .rn_block(rn_block), .rn_unblock(rn_unblock),
      .ex_block(ex_block), .ex_unblock(ex_unblock),
      .cm_block(cm_block), .cm_unblock(cm_unblock),
      .cm_squash(cm_squash), .cm_busy(cm_busy),
      .out_vld(out_vld), .out_tid(out_tid), .out_seq(out_seq),
      .fe_block(fe_block), .fe_unblock(fe_unblock), .thr_state(thr_state)
   );

   task automatic clr_in();
      fg_vld = '0; fg_kill = '0; fg_tid = '0; fg_seq = '0;
      rn_block = '0; rn_unblock = '0; ex_block = '0; ex_unblock = '0;
      cm_block = '0; cm_unblock = '0; cm_squash = '0; cm_busy = '0;
   endtask

   task automatic put(input int lane, input int tid, input int seq, input bit kill = 1'b0);
      fg_vld[lane] = 1'b1;
      fg_kill[lane] = kill;
      fg_tid[lane*TID_W +: TID_W] = TID_W'(tid);
      fg_seq[lane*SEQ_W +: SEQ_W] = SEQ_W'(seq);
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_out(input string tag, input int n,
                          input int t0 = 0, input int s0 = 0,
                          input int t1 = 0, input int s1 = 0);
      chk_eq({tag, " lanes"}, int'(out_vld), (1 << n) - 1);
      if (n > 0) begin
         chk_eq({tag, " lane0 tid"}, int'(out_tid[0 +: TID_W]), t0);
         chk_eq({tag, " lane0 seq"}, int'(out_seq[0 +: SEQ_W]), s0);
      end
      if (n > 1) begin
         chk_eq({tag, " lane1 tid"}, int'(out_tid[TID_W +: TID_W]), t1);
         chk_eq({tag, " lane1 seq"}, int'(out_seq[SEQ_W +: SEQ_W]), s1);
      end
   endtask

   task automatic chk_st(input string tag, input int t, input int exp);
      chk_eq({tag, " state"}, int'(thr_state[3*t +: 3]), exp);
   endtask

   task automatic chk_fe(input string tag, input int blk, input int ublk);
      chk_eq({tag, " fe_block"}, int'(fe_block), blk);
      chk_eq({tag, " fe_unblock"}, int'(fe_unblock), ublk);
   endtask

   task automatic t_reset();
      clr_in();
      rst_n = 1'b0;
      repeat (3) cyc();
      chk_st("R1 reset t0", 0, 0);
      chk_st("R1 reset t1", 1, 0);
      chk_out("R1 reset", 0);
      chk_fe("R1 reset", 0, 0);
      rst_n = 1'b1;
      cyc();
      chk_st("R1 idle after release", 0, 0);
   endtask

   task automatic t_basic();
      put(0, 0, 1); put(1, 0, 2);
      cyc();
      chk_out("R4 basic", 2, 0, 1, 0, 2);
      chk_st("R4 idle to run", 0, 1);
      chk_st("R4 other idle", 1, 0);
      chk_fe("R4 basic", 0, 0);
      clr_in(); cyc();
      chk_out("R4 quiet", 0);
   endtask

   task automatic t_kill_order();
      put(0, 1, 10); put(1, 0, 20, 1'b1); put(2, 0, 21);
      cyc();
      chk_out("R5 kill / R4 thread order", 2, 0, 21, 1, 10);
      chk_st("R4 t1 runs", 1, 1);
      chk_fe("R5 no block", 0, 0);
      clr_in();
   endtask

   task automatic t_overflow();
      put(0, 0, 30); put(1, 0, 31); put(2, 0, 32);
      cyc();
      chk_out("R6 width cap", 2, 0, 30, 0, 31);
      chk_st("R6 blocked", 0, 2);
      chk_fe("R6 block pulse", 1, 0);
      clr_in(); put(0, 0, 40); put(1, 0, 41);
      cyc();
      chk_out("R8 skid first", 2, 0, 32, 0, 40);
      chk_st("R8 unblocking", 0, 3);
      chk_fe("R8 no pulse yet", 0, 0);
      clr_in(); cyc();
      chk_out("R8 tail", 1, 0, 41);
      chk_st("R8 running", 0, 1);
      chk_fe("R8 unblock pulse", 0, 1);
   endtask

   task automatic t_stall();
      clr_in(); rn_block[1] = 1'b1; put(0, 1, 50); put(1, 1, 51);
      cyc();
      chk_out("R7 held silent", 0);
      chk_st("R7 blocked", 1, 2);
      chk_fe("R7 first block pulse", 2, 0);
      clr_in(); ex_block[1] = 1'b1; put(0, 1, 52);
      cyc();
      chk_out("R7 still silent", 0);
      chk_fe("R7 no repeat pulse", 0, 0);
      clr_in(); rn_unblock[1] = 1'b1; put(0, 1, 53);
      cyc();
      chk_out("R2 execute flag holds", 0);
      chk_st("R2 still blocked", 1, 2);
      clr_in(); ex_unblock[1] = 1'b1; put(0, 0, 60);
      cyc();
      chk_out("R4 priority in drain", 2, 0, 60, 1, 50);
      chk_st("R8 t1 unblocking", 1, 3);
      chk_fe("R8 drain no pulse", 0, 0);
      clr_in(); cyc();
      chk_out("R8 drain order", 2, 1, 51, 1, 52);
      cyc();
      chk_out("R8 drain last", 1, 1, 53);
      chk_st("R8 t1 running", 1, 1);
      chk_fe("R8 t1 unblock pulse", 0, 2);
   endtask

   task automatic t_squash();
      clr_in(); cm_block[0] = 1'b1; put(0, 0, 70); put(1, 0, 71);
      cyc();
      chk_st("R2 commit hold", 0, 2);
      chk_fe("R2 commit hold pulse", 1, 0);
      clr_in(); cm_squash[0] = 1'b1; cm_unblock[0] = 1'b1; put(0, 0, 72);
      cyc();
      chk_out("R9 squash silent", 0);
      chk_st("R9 squashing", 0, 4);
      chk_fe("R9 unblock from blocked", 0, 1);
      clr_in(); cm_busy[0] = 1'b1; put(0, 0, 73);
      cyc();
      chk_out("R10 busy silent", 0);
      chk_st("R10 hold squashing", 0, 4);
      chk_fe("R10 no pulse", 0, 0);
      clr_in(); put(0, 0, 74);
      cyc();
      chk_out("R9 skid flushed", 1, 0, 74);
      chk_st("R10 back to running", 0, 1);
   endtask

   task automatic t_priority();
      clr_in(); rn_block[0] = 1'b1; cm_squash[0] = 1'b1; put(0, 0, 80);
      cyc();
      chk_out("R11 squash over hold", 0);
      chk_st("R11 squash wins", 0, 4);
      chk_fe("R9 no unblock from running", 0, 0);
      clr_in(); cyc();
      chk_st("R2 flag survived squash", 0, 2);
      chk_fe("R7 pulse after squash", 1, 0);
      clr_in(); rn_unblock[0] = 1'b1;
      cyc();
      chk_st("R8 empty drain", 0, 1);
      chk_fe("R8 empty drain pulse", 0, 1);
      clr_in(); cm_busy[1] = 1'b1; ex_block[1] = 1'b1; put(0, 1, 90);
      cyc();
      chk_out("R11 busy over hold", 0);
      chk_st("R11 busy wins", 1, 4);
      chk_fe("R11 no block pulse", 0, 0);
      clr_in(); ex_unblock[1] = 1'b1;
      cyc();
      chk_st("R10 squash to run", 1, 1);
      chk_out("R10 dropped input", 0);
   endtask

   task automatic t_capacity();
      clr_in(); cm_block[1] = 1'b1;
      for (int i = 0; i < 4; i++) put(i, 1, 100 + i);
      cyc();
      chk_fe("R3 fill block", 2, 0);
      clr_in();
      for (int i = 0; i < 4; i++) put(i, 1, 104 + i);
      cyc();
      clr_in(); put(0, 1, 108); put(1, 1, 109);
      cyc();
      chk_out("R3 full silent", 0);
      clr_in(); cm_unblock[1] = 1'b1;
      for (int k = 0; k < 5; k++) begin
         cyc();
         clr_in();
         chk_out("R3 full drain", 2, 1, 100 + 2*k, 1, 101 + 2*k);
      end
      chk_st("R3 drained running", 1, 1);
      chk_fe("R3 drained pulse", 0, 2);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog R1 act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_basic();
      t_kill_order();
      t_overflow();
      t_stall();
      t_squash();
      t_priority();
      t_capacity();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule